// File: doc/BRIEF.md
# Parallel-load shift register with J / K-bar serial entry

This block is a small register of `WIDTH` stages (four by default) that either captures a parallel word or shifts its contents by one place. The choice is made by the `shift_en` control, which is sampled on each rising clock edge. When `shift_en` is low, the edge loads the parallel word. When it is high, the edge moves every stage one place from stage 0 toward the last stage.

While shifting, stage 0 does not simply copy a serial bit. It acts as a J / K-bar flip-flop, so a pair of serial inputs can make it hold, clear, set or toggle. Software-free glue logic uses this to build counters, pattern generators or serial-to-parallel converters. The last stage is also driven out in complemented form. An active-low clear empties the register at once, without waiting for the clock.

Internally, each stage is a cell with two named operations, OP_LOAD and OP_SHIFT, picked from `shift_en`. The first-stage action has four named values: ACT_HOLD, ACT_CLEAR, ACT_SET and ACT_TOGGLE. Its next value is decoded from the J / K-bar pair. A cell moves from its current value to its next value only on a rising edge, and goes to zero on clear.

Top module: `pshift_reg`

## Requirements
- R1: While `clr_n` is low, every bit of `q_out` is 0. This takes effect at once, without a clock edge, and overrides every other input.
- R2: At a rising edge with `shift_en` = 0 and `clr_n` high, `q_out[i]` takes `par_in[i]` for every i.
- R3: During a load edge (`shift_en` = 0), `j_in` and `kbar_in` have no effect on any stage.
- R4: At a rising edge with `shift_en` = 1, `q_out[i]` takes the previous `q_out[i-1]` for every i from 1 to WIDTH-1.
- R5: At a rising edge with `shift_en` = 1, stage 0 follows the {`j_in`,`kbar_in`} pair: 01 holds, 00 clears to 0, 11 sets to 1, and 10 toggles.
- R6: With `clr_n` high, input changes between rising edges leave `q_out` unchanged.
- R7: After `clr_n` returns high, `q_out` stays 0 until the next rising edge.
- R8: `q_last_n` always equals the inverse of `q_out[WIDTH-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes except clear occur on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| shift_en | input | 1 | 1 = shift one place at the edge, 0 = parallel load |
| j_in | input | 1 | J serial input of stage 0 |
| kbar_in | input | 1 | Inverted-K serial input of stage 0 |
| par_in | input | WIDTH | Parallel data; bit i loads stage i |
| q_out | output | WIDTH | Stage values; bit 0 is the first stage |
| q_last_n | output | 1 | Complement of the last stage |

## Verification
Load and shift results appear one rising edge after the inputs are set up. The bench drives inputs at the falling edge and samples 1 ns after the following rising edge, so every check lands exactly one register delay after its stimulus. Clear acts with zero clock delay, so it is asserted mid-cycle and checked 1 ns later, before any edge could be involved. The hold-between-edges check and the release-of-clear check are likewise sampled before the next rising edge, and the result of that edge is checked 1 ns after it.

// File: rtl/pshift_pkg.sv
package pshift_pkg;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_SHIFT = 1'b1
    } cell_op_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_SET,
        ACT_TOGGLE
    } head_act_t;

endpackage

// File: rtl/pshift_head.sv
module pshift_head
    import pshift_pkg::*;
(
    input  logic j_in,
    input  logic kbar_in,
    input  logic cur_q,
    output logic nxt_q
);

    head_act_t act;

    // Decode the serial pair into a named first-stage action
    always_comb begin
        unique case ({j_in, kbar_in})
            2'b01:   act = ACT_HOLD;
            2'b00:   act = ACT_CLEAR;
            2'b11:   act = ACT_SET;
            default: act = ACT_TOGGLE;
        endcase
    end

    always_comb begin
        unique case (act)
            ACT_HOLD:   nxt_q = cur_q;
            ACT_CLEAR:  nxt_q = 1'b0;
            ACT_SET:    nxt_q = 1'b1;
            ACT_TOGGLE: nxt_q = ~cur_q;
            default:    nxt_q = cur_q;
        endcase
    end

endmodule

// File: rtl/pshift_cell.sv
module pshift_cell
    import pshift_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic shift_en,
    input  logic load_d,
    input  logic shift_d,
    output logic q
);

    cell_op_t op;
    logic     d_next;

    always_comb begin
        op = shift_en ? OP_SHIFT : OP_LOAD;
    end

    always_comb begin
        unique case (op)
            OP_LOAD:  d_next = load_d;
            OP_SHIFT: d_next = shift_d;
            default:  d_next = load_d;
        endcase
    end

    // State register with asynchronous active-low clear
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else begin
            q <= d_next;
        end
    end

endmodule

// File: rtl/pshift_reg.sv
module pshift_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             shift_en,
    input  logic             j_in,
    input  logic             kbar_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q_out,
    output logic             q_last_n
);

    localparam int LAST = WIDTH - 1;

    logic [WIDTH-1:0] shift_src;
    logic             head_nxt;

    pshift_head u_head (
        .j_in    (j_in),
        .kbar_in (kbar_in),
        .cur_q   (q_out[0]),
        .nxt_q   (head_nxt)
    );

    assign shift_src[0] = head_nxt;

    genvar g;
    generate
        for (g = 1; g < WIDTH; g++) begin : g_link
            assign shift_src[g] = q_out[g-1];
        end
        for (g = 0; g < WIDTH; g++) begin : g_stage
            pshift_cell u_cell (
                .clk      (clk),
                .clr_n    (clr_n),
                .shift_en (shift_en),
                .load_d   (par_in[g]),
                .shift_d  (shift_src[g]),
                .q        (q_out[g])
            );
        end
    endgenerate

    assign q_last_n = ~q_out[LAST];

    // R1: clear holds every stage at zero
    a_r1_clear_zero: assert property (@(posedge clk)
        !clr_n |-> q_out == '0);

    // R2, R3: a load edge takes the parallel word regardless of the serial pair
    a_r2_load_word: assert property (@(posedge clk) disable iff (!clr_n)
        !shift_en |=> q_out == $past(par_in));

    // R4: each later stage takes its predecessor
    generate
        for (g = 1; g < WIDTH; g++) begin : g_chk
            a_r4_shift_chain: assert property (@(posedge clk) disable iff (!clr_n)
                shift_en |=> q_out[g] == $past(q_out[g-1]));
        end
    endgenerate

    // R5: toggle inverts stage 0
    a_r5_toggle: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_en && j_in && !kbar_in) |=> q_out[0] != $past(q_out[0]));

    // R5: hold keeps stage 0
    a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_en && !j_in && kbar_in) |=> $stable(q_out[0]));

    // R5: set and clear force stage 0
    a_r5_set_clear: assert property (@(posedge clk) disable iff (!clr_n)
        (shift_en && (j_in == kbar_in)) |=> q_out[0] == $past(j_in));

endmodule

// File: tb/pshift_reg_test.sv
module pshift_reg_test;

    logic       clk = 1'b0;
    logic       clr_n;
    logic       shift_en;
    logic       j_in;
    logic       kbar_in;
    logic [3:0] par_in;
    logic [3:0] q_out;
    logic       q_last_n;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    pshift_reg #(.WIDTH(4)) uut (
        .clk      (clk),
        .clr_n    (clr_n),
        .shift_en (shift_en),
        .j_in     (j_in),
        .kbar_in  (kbar_in),
        .par_in   (par_in),
        .q_out    (q_out),
        .q_last_n (q_last_n)
    );

    // {shift_en, j_in, kbar_in, par_in[3:0], expected q_out[3:0]}
    localparam int NVEC = 12;
    localparam logic [10:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 1'b0, 4'b1011, 4'b1011},  // R2 R3 load, toggle pair ignored
        {1'b1, 1'b0, 1'b1, 4'b0000, 4'b0111},  // R4 R5 hold
        {1'b1, 1'b0, 1'b0, 4'b0000, 4'b1110},  // R5 clear
        {1'b1, 1'b1, 1'b0, 4'b0000, 4'b1101},  // R5 toggle 0->1
        {1'b1, 1'b1, 1'b0, 4'b0000, 4'b1010},  // R5 toggle 1->0
        {1'b1, 1'b1, 1'b1, 4'b0000, 4'b0101},  // R5 set
        {1'b0, 1'b1, 1'b1, 4'b0000, 4'b0000},  // R3 set pair ignored
        {1'b1, 1'b0, 1'b1, 4'b1111, 4'b0000},  // R4 parallel ignored in shift
        {1'b1, 1'b1, 1'b1, 4'b0000, 4'b0001},  // R5 set
        {1'b1, 1'b0, 1'b1, 4'b0000, 4'b0011},  // R5 hold
        {1'b1, 1'b0, 1'b0, 4'b0000, 4'b0110},  // R5 clear
        {1'b0, 1'b0, 1'b0, 4'b1100, 4'b1100}   // R2 R3 load, clear pair ignored
    };

    task automatic check(input string req, input logic [3:0] exp);
        n_checks++;
        if (q_out !== exp || q_last_n !== ~exp[3]) begin
            n_fails++;
            $display("FAIL %s: q_out=%b q_last_n=%b expected q_out=%b q_last_n=%b",
                     req, q_out, q_last_n, exp, ~exp[3]);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        clr_n    = 1'b1;
        shift_en = 1'b0;
        j_in     = 1'b0;
        kbar_in  = 1'b1;
        par_in   = 4'b1111;
        #1 clr_n = 1'b0;
        @(posedge clk);
        #1 check("R1 reset state", 4'b0000);
        @(negedge clk);
        clr_n = 1'b1;
        #1 check("R7 zero after release", 4'b0000);
        shift_en = 1'b1;
        j_in     = 1'b0;
        kbar_in  = 1'b0;

        // Vector table: R2 R3 R4 R5 R8
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            shift_en = VEC[v][10];
            j_in     = VEC[v][9];
            kbar_in  = VEC[v][8];
            par_in   = VEC[v][7:4];
            @(posedge clk);
            #1 check(VEC[v][10] ? "R4 R5 R8 shift" : "R2 R3 R8 load", VEC[v][3:0]);
        end

        // R6: changes between edges have no effect
        @(negedge clk);
        shift_en = 1'b0;
        par_in   = 4'b0011;
        j_in     = 1'b1;
        kbar_in  = 1'b0;
        #2 shift_en = 1'b1;
        #1 shift_en = 1'b0;
        check("R6 hold between edges", 4'b1100);
        @(posedge clk);
        #1 check("R2 load after idle", 4'b0011);

        // R1: clear mid-cycle, no edge needed
        @(negedge clk);
        shift_en = 1'b0;
        par_in   = 4'b1111;
        #2 clr_n = 1'b0;
        #1 check("R1 async clear", 4'b0000);
        @(posedge clk);
        #1 check("R1 clear overrides load", 4'b0000);

        // R7: release mid-cycle, stays zero until the edge
        @(negedge clk);
        #2 clr_n = 1'b1;
        #1 check("R7 zero until edge", 4'b0000);
        @(posedge clk);
        #1 check("R2 R8 load after release", 4'b1111);

        // R5 toggle from all ones with a shift
        @(negedge clk);
        shift_en = 1'b1;
        j_in     = 1'b1;
        kbar_in  = 1'b0;
        @(posedge clk);
        #1 check("R5 R8 toggle 1->0", 4'b1110);

        finish_run();
    end

endmodule